// File: doc/BRIEF.md
# Comparator Edge Interrupt Controller

This block is the digital side of an on-chip voltage comparator in a small microcontroller. It brings the comparator's asynchronous result into the clock domain and watches it for a chosen kind of change: a rising edge, a falling edge or either edge. When that change occurs it sets a sticky pending flag. It requests an interrupt when the flag, the local enable and the processor's global interrupt enable are all set. The flag clears when the interrupt controller acknowledges the request, or when software writes one to the flag bit.

All control and status is held in one 8-bit register on a simple address/write-enable/data bus. Two register bits drive the analog side directly. One powers the comparator down. The other switches the comparator's positive input from the pin to a fixed internal reference.

Two small state machines do the work. The edge tracker has states EDG_LOW and EDG_HIGH and holds the last synchronized level. It moves EDG_LOW→EDG_HIGH when the level reads 1 and EDG_HIGH→EDG_LOW when it reads 0. A move is reported as a rise or fall event, which the trigger mode filters. The flag machine has states FLG_IDLE and FLG_PEND. It moves FLG_IDLE→FLG_PEND on a filtered event and FLG_PEND→FLG_IDLE on a clear request that comes without an event in the same cycle. All other cases hold the state.

Top module: `cmp_irq_ctrl`

## Requirements
- R1: The register reads at address `REG_ADDR` as {bit7 power-down, bit6 reference select, bit5 synchronized level, bit4 pending flag, bit3 interrupt enable, bit2 constant 0, bits1:0 trigger mode}. Every bit is 0 after reset except bit5, which shows the level. Any other address reads 0.
- R2: Writes to bits 5 and 2 are ignored. Bits 7, 6, 3 and 1:0 take the written value.
- R3: Bit 5 shows the comparator input after two clock edges of synchronization. It is 1 when the positive input is above the negative input.
- R4: Trigger mode 2'b00 sets the flag on any change of the level, 2'b10 on a fall, 2'b11 on a rise, and 2'b01 never sets it. The flag is set on the edge after the new level first appears in bit 5.
- R5: The flag is cleared by `irq_ack`, or by a register write with bit 4 equal to 1. A write with bit 4 equal to 0 leaves the flag unchanged.
- R6: If a flag-setting event and a clear request fall in the same cycle, the flag ends up set.
- R7: `irq_req` is 1 exactly when the flag, the interrupt enable bit and `glob_ie` are all 1.
- R8: `ref_sel_o` follows register bit 6.
- R9: `pwr_down_o` follows register bit 7. While it is set, the level and bit 5 are held at 0. A level of 1 forced to 0 this way counts as a falling change for the trigger modes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmp_raw | input | 1 | Asynchronous comparator result |
| bus_addr | input | ADDR_W | Register address |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data (combinational) |
| glob_ie | input | 1 | Processor global interrupt enable |
| irq_ack | input | 1 | Interrupt taken; clears the flag |
| irq_req | output | 1 | Interrupt request |
| ref_sel_o | output | 1 | Selects the internal reference for the positive input |
| pwr_down_o | output | 1 | Powers down the comparator |

## Verification
The embedded assertions check a set of rules on every cycle:
- an event always leaves the flag set, even when a clear arrives with it;
- a clear without an event always empties the flag;
- without a set or a clear the flag never changes;
- the reserved mode never raises the flag;
- the level reads 0 while powered down;
- the reference select follows each write.

Other behaviour needs the bench's directed scenarios, driven against its cycle model:
- the two-edge latency through the synchronizer;
- the choice among the three edge kinds;
- the spurious fall that powering down produces;
- writes of 0 to the flag that must do nothing.

// File: rtl/cmpi_pkg.sv
package cmpi_pkg;

    localparam int unsigned REG_W   = 8;
    localparam int unsigned BIT_OFF = 7;
    localparam int unsigned BIT_REF = 6;
    localparam int unsigned BIT_LVL = 5;
    localparam int unsigned BIT_FLG = 4;
    localparam int unsigned BIT_IE  = 3;
    localparam int unsigned BIT_NC  = 2;

    typedef enum logic [1:0] {
        MODE_ANY  = 2'b00,
        MODE_NONE = 2'b01,
        MODE_FALL = 2'b10,
        MODE_RISE = 2'b11
    } trig_mode_e;

    typedef enum logic {
        EDG_LOW  = 1'b0,
        EDG_HIGH = 1'b1
    } edge_state_e;

    typedef enum logic {
        FLG_IDLE = 1'b0,
        FLG_PEND = 1'b1
    } flag_state_e;

endpackage

// File: rtl/cmpi_sync.sv
module cmpi_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic d,
    output logic q
);

    logic [STAGES-1:0] chain;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain <= '0;
        end else if (clr) begin
            chain <= '0;
        end else begin
            chain[0] <= d;
            for (int i = 1; i < int'(STAGES); i++) begin
                chain[i] <= chain[i-1];
            end
        end
    end

    assign q = chain[STAGES-1];

    AST_SYNC_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> !q); // R9

endmodule

// File: rtl/cmpi_edge_fsm.sv
module cmpi_edge_fsm
    import cmpi_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       level,
    input  trig_mode_e mode,
    output logic       trig
);

    edge_state_e state_q, state_d;
    logic        rise, fall;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            EDG_LOW:  if (level)  state_d = EDG_HIGH;
            EDG_HIGH: if (!level) state_d = EDG_LOW;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= EDG_LOW;
        else        state_q <= state_d;
    end

    always_comb begin
        rise = (state_q == EDG_LOW)  && (state_d == EDG_HIGH);
        fall = (state_q == EDG_HIGH) && (state_d == EDG_LOW);
        unique case (mode)
            MODE_ANY:  trig = rise | fall;
            MODE_NONE: trig = 1'b0;
            MODE_FALL: trig = fall;
            MODE_RISE: trig = rise;
        endcase
    end

    AST_RISE_NEEDS_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (trig && mode == MODE_RISE) |-> level); // R4
    AST_FALL_NEEDS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (trig && mode == MODE_FALL) |-> !level); // R4

endmodule

// File: rtl/cmpi_flag_fsm.sv
module cmpi_flag_fsm
    import cmpi_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic set_ev,
    input  logic clr_req,
    output logic flag
);

    flag_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            FLG_IDLE: if (set_ev)             state_d = FLG_PEND;
            FLG_PEND: if (clr_req && !set_ev) state_d = FLG_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= FLG_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        flag = (state_q == FLG_PEND);
    end

    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        set_ev |=> flag); // R6
    AST_CLEAR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_req && !set_ev) |=> !flag); // R5
    AST_FLAG_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_req && !set_ev) |=> $stable(flag)); // R5

endmodule

// File: rtl/cmp_irq_ctrl.sv
module cmp_irq_ctrl
    import cmpi_pkg::*;
#(
    parameter int unsigned ADDR_W      = 6,
    parameter int unsigned REG_ADDR    = 8,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmp_raw,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [7:0]        bus_wdata,
    output logic [7:0]        bus_rdata,
    input  logic              glob_ie,
    input  logic              irq_ack,
    output logic              irq_req,
    output logic              ref_sel_o,
    output logic              pwr_down_o
);

    localparam logic [ADDR_W-1:0] MY_ADDR = ADDR_W'(REG_ADDR);

    logic       off_q, ref_q, ie_q;
    trig_mode_e mode_q;
    logic       hit, wr_hit, clr_req;
    logic       level, trig, flag;
    logic       wdata_unused;

    assign hit          = (bus_addr == MY_ADDR);
    assign wr_hit       = bus_we && hit;
    assign wdata_unused = ^{bus_wdata[BIT_LVL], bus_wdata[BIT_NC]};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            off_q  <= 1'b0;
            ref_q  <= 1'b0;
            ie_q   <= 1'b0;
            mode_q <= MODE_ANY;
        end else if (wr_hit) begin
            off_q  <= bus_wdata[BIT_OFF];
            ref_q  <= bus_wdata[BIT_REF];
            ie_q   <= bus_wdata[BIT_IE];
            mode_q <= trig_mode_e'(bus_wdata[1:0]);
        end
    end

    cmpi_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (off_q),
        .d     (cmp_raw),
        .q     (level)
    );

    cmpi_edge_fsm u_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .level (level),
        .mode  (mode_q),
        .trig  (trig)
    );

    assign clr_req = irq_ack | (wr_hit & bus_wdata[BIT_FLG]);

    cmpi_flag_fsm u_flag (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_ev  (trig),
        .clr_req (clr_req),
        .flag    (flag)
    );

    always_comb begin
        bus_rdata = '0;
        if (hit) begin
            bus_rdata[BIT_OFF] = off_q;
            bus_rdata[BIT_REF] = ref_q;
            bus_rdata[BIT_LVL] = level;
            bus_rdata[BIT_FLG] = flag;
            bus_rdata[BIT_IE]  = ie_q;
            bus_rdata[BIT_NC]  = 1'b0;
            bus_rdata[1:0]     = mode_q;
        end
    end

    assign irq_req    = flag & ie_q & glob_ie;
    assign ref_sel_o  = ref_q;
    assign pwr_down_o = off_q;

    AST_REF_FOLLOWS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_hit |=> (ref_sel_o == $past(bus_wdata[BIT_REF]))); // R8
    AST_RESERVED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == MODE_NONE && !flag) |=> !flag); // R4
    AST_IRQ_NEEDS_GIE: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> glob_ie); // R7
    AST_OFF_LEVEL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_down_o && $past(pwr_down_o)) |-> !level); // R9

endmodule

// File: tb/test_cmp_irq_ctrl.sv
module test_cmp_irq_ctrl;

    localparam int ADDR_W = 6;
    localparam logic [ADDR_W-1:0] RADDR = 6'd8;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              cmp_raw = 1'b0;
    logic [ADDR_W-1:0] bus_addr = RADDR;
    logic              bus_we = 1'b0;
    logic [7:0]        bus_wdata = 8'h00;
    logic [7:0]        bus_rdata;
    logic              glob_ie = 1'b0;
    logic              irq_ack = 1'b0;
    logic              irq_req, ref_sel_o, pwr_down_o;

    int  checks = 0;
    int  failures = 0;
    bit  done = 1'b0;

    always #2 clk = ~clk;

    cmp_irq_ctrl #(.ADDR_W(ADDR_W), .REG_ADDR(8), .SYNC_STAGES(2)) i_cmp_irq_ctrl (
        .clk(clk), .rst_n(rst_n), .cmp_raw(cmp_raw), .bus_addr(bus_addr),
        .bus_we(bus_we), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .glob_ie(glob_ie), .irq_ack(irq_ack), .irq_req(irq_req),
        .ref_sel_o(ref_sel_o), .pwr_down_o(pwr_down_o)
    );

    // behavioural reference model
    bit       m_off, m_ref, m_ie, m_flag, m_prev;
    bit [1:0] m_mode;
    bit       m_pipe[$];

    function automatic bit m_level();
        return m_pipe[0];
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_off = 0; m_ref = 0; m_ie = 0; m_flag = 0; m_prev = 0; m_mode = 0;
            m_pipe = '{1'b0, 1'b0};
        end else begin
            bit lv, ev, clr, wr;
            lv = m_level();
            case (m_mode)
                2'd0: ev = (lv != m_prev);
                2'd1: ev = 0;
                2'd2: ev = m_prev && !lv;
                default: ev = !m_prev && lv;
            endcase
            wr  = bus_we && (bus_addr == RADDR);
            clr = irq_ack || (wr && bus_wdata[4]);
            if (ev) m_flag = 1;
            else if (clr) m_flag = 0;
            m_prev = lv;
            if (m_off) m_pipe = '{1'b0, 1'b0};
            else begin
                void'(m_pipe.pop_front());
                m_pipe.push_back(cmp_raw);
            end
            if (wr) begin
                m_off = bus_wdata[7]; m_ref = bus_wdata[6];
                m_ie = bus_wdata[3]; m_mode = bus_wdata[1:0];
            end
        end
    end

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n && !done) begin
            logic [7:0] e;
            e = (bus_addr == RADDR) ?
                {m_off, m_ref, m_level(), m_flag, m_ie, 1'b0, m_mode} : 8'h00;
            chk("R1 readback vs model", bus_rdata, e);
            chk("R7 irq vs model", {7'd0, irq_req}, {7'd0, m_flag & m_ie & glob_ie});
            chk("R8 ref_sel vs model", {7'd0, ref_sel_o}, {7'd0, m_ref});
            chk("R9 pwr_down vs model", {7'd0, pwr_down_o}, {7'd0, m_off});
        end
    end

    task automatic tick(input int n = 1);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            #1;
        end
    endtask

    task automatic wr(input logic [7:0] d);
        bus_we = 1'b1; bus_wdata = d;
        tick();
        bus_we = 1'b0; bus_wdata = 8'h00;
    endtask

    initial begin
        #400000;
        if (!done) begin
            done = 1'b1;
            failures++;
            $display("FAIL watchdog expired");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        tick(3);
        rst_n = 1'b1;
        tick();
        chk("R1 reset value", bus_rdata, 8'h00);
        chk("R7 irq after reset", {7'd0, irq_req}, 8'h00);
        glob_ie = 1'b1;

        wr(8'b0010_1111);
        chk("R2 read-only bits ignore write", bus_rdata, 8'h0B);

        cmp_raw = 1'b1;
        tick();
        chk("R3 level not yet through sync", {7'd0, bus_rdata[5]}, 8'h00);
        tick();
        chk("R3 level after two edges", bus_rdata, 8'h2B);
        tick();
        chk("R4 rise sets flag", bus_rdata, 8'h3B);
        chk("R7 irq raised", {7'd0, irq_req}, 8'h01);

        wr(8'h0B);
        chk("R5 write 0 keeps flag", {7'd0, bus_rdata[4]}, 8'h01);
        wr(8'h1B);
        chk("R5 write 1 clears flag", {7'd0, bus_rdata[4]}, 8'h00);

        wr(8'h0A);
        cmp_raw = 1'b0;
        tick(3);
        chk("R4 fall sets flag", {7'd0, bus_rdata[4]}, 8'h01);
        irq_ack = 1'b1; tick(); irq_ack = 1'b0;
        chk("R5 ack clears flag", {7'd0, bus_rdata[4]}, 8'h00);

        wr(8'h09);
        cmp_raw = 1'b1; tick(4);
        chk("R4 reserved mode ignores rise", {7'd0, bus_rdata[4]}, 8'h00);
        cmp_raw = 1'b0; tick(4);
        chk("R4 reserved mode ignores fall", {7'd0, bus_rdata[4]}, 8'h00);

        wr(8'h08);
        cmp_raw = 1'b1; tick(3);
        chk("R4 toggle on rise", {7'd0, bus_rdata[4]}, 8'h01);
        wr(8'h18);
        cmp_raw = 1'b0; tick(3);
        chk("R4 toggle on fall", {7'd0, bus_rdata[4]}, 8'h01);

        cmp_raw = 1'b1; tick(2);
        irq_ack = 1'b1; tick(); irq_ack = 1'b0;
        chk("R6 set wins over ack", {7'd0, bus_rdata[4]}, 8'h01);

        glob_ie = 1'b0; #1;
        chk("R7 global enable off", {7'd0, irq_req}, 8'h00);
        glob_ie = 1'b1; #1;
        chk("R7 all enables on", {7'd0, irq_req}, 8'h01);
        wr(8'h00);
        chk("R7 local enable off", {7'd0, irq_req}, 8'h00);

        wr(8'h40);
        chk("R8 reference select set", {7'd0, ref_sel_o}, 8'h01);
        chk("R8 readback bit6", {7'd0, bus_rdata[6]}, 8'h01);

        wr(8'h50);
        wr(8'hC0);
        chk("R9 power-down out", {7'd0, pwr_down_o}, 8'h01);
        tick();
        chk("R9 level held low", {7'd0, bus_rdata[5]}, 8'h00);
        tick();
        chk("R9 forced fall sets flag", {7'd0, bus_rdata[4]}, 8'h01);
        cmp_raw = 1'b0; tick(3); cmp_raw = 1'b1; tick(3);
        chk("R9 level stays low while off", {7'd0, bus_rdata[5]}, 8'h00);

        bus_addr = 6'd3; #1;
        chk("R1 other address reads zero", bus_rdata, 8'h00);
        bus_addr = RADDR;
        tick(2);

        done = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule